// File: doc/BRIEF.md
# UART control and status register unit

This block is the software-facing register file of a small serial port. A 32-bit word-addressed bus reaches five registers in a 0x14-byte window. Through them software reads received characters, writes characters to send, sets the line format, the baud divisor and the interrupt enables, and reads the live state of both FIFOs. The receive and transmit engines and their FIFOs sit outside. They see this unit only through pop and push strobes, FIFO flag inputs, error event pulses, one-cycle flush strobes and static configuration outputs.

Nine interrupt enables are each paired with one status flag. The interrupt line is the registered OR of every enabled, active source. Four line-error flags (break, framing, parity, overrun) are sticky: each is captured from a one-cycle event pulse and is cleared by reading the status word. When status mirroring is on, each received character read from the receive buffer carries its own four error tags. The control word also drives flush strobes for each FIFO, and a soft-reset strobe that also clears the whole register file.

Top module: `uart_csr_unit`

## Requirements
- R1: While reset is held and right after it is released, the control word, the divisor and the sticky error flags are 0, and irq, tx_push, rx_pop, txf_flush, rxf_flush and soft_clear are low.
- R2: Register offsets are 0x00 receive buffer, 0x04 transmit holding, 0x08 control, 0x0C status and 0x10 divisor. A control write stores bits 31 and 15:0, and bits 30:16 read 0. The outputs follow the stored bits: bit 12 cfg_loopback, bit 11 cfg_break, bit 10 cfg_parity, bit 9 cfg_two_stop. Bit 13 turns on status mirroring.
- R3: A control write with bit 15 set makes txf_flush high for exactly the one cycle after the write edge. Bit 14 does the same for rxf_flush. Both bits read back as written.
- R4: A control write with bit 31 set makes soft_clear high for the one cycle after the write edge, and at that same edge it clears the control word, the divisor and the sticky flags.
- R5: A divisor write changes only bits 9:0, which drive cfg_div. Bits 31:10 of the divisor register read 0.
- R6: The status word has these bits: 13 TX FIFO empty, 12 RX FIFO empty, 11 TX FIFO full, 10 TX FIFO half, 9 RX toggled, 8 RX FIFO full, 7 RX FIFO half, 6 transmitter empty, 5 TX ready, 4 RX ready (= not RX FIFO empty), 3 break, 2 frame, 1 parity, 0 overrun. All other bits are 0.
- R7: A pulse on err_event[3:0] (break, frame, parity, overrun) sets status bits 3:0 at the next edge. A status read returns the flags as they are and clears them at its edge, except for an event that arrives in the same cycle, which stays set.
- R8: A write to the status offset changes no register.
- R9: irq goes high one cycle after any enable bit is set together with its source. The enable-to-source pairs are: control bit 8 with status bit 10, control bit 7 with status bit 7, and control bits 6..0 with status bits 6..0.
- R10: A receive-buffer read while the RX FIFO is not empty returns the character in bits 7:0 and raises rx_pop in that cycle. With mirroring on, bits 15:12 carry rx_flags (break, frame, parity, overrun). With mirroring off, those bits are 0. A read of an empty FIFO returns 0 and does not pop.
- R11: A write to the transmit holding offset raises tx_push for the one cycle after the write edge, with tx_byte equal to wdata[7:0]. No push is made if tx_fifo_full is high when the write is made.
- R12: Offsets 0x14 to 0x1C, misaligned addresses and reads of the transmit holding offset return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the read cycle |
| rx_byte | input | 8 | Character at the head of the RX FIFO |
| rx_flags | input | 4 | Error tags of that character {break, frame, parity, overrun} |
| rx_pop | output | 1 | Remove the head character |
| rx_fifo_empty | input | 1 | RX FIFO empty |
| rx_fifo_full | input | 1 | RX FIFO full |
| rx_fifo_half | input | 1 | RX FIFO at least half full |
| rx_toggled | input | 1 | Receive line activity seen |
| tx_byte | output | 8 | Character to push |
| tx_push | output | 1 | Push tx_byte into the TX FIFO |
| tx_fifo_empty | input | 1 | TX FIFO empty |
| tx_fifo_full | input | 1 | TX FIFO full |
| tx_fifo_half | input | 1 | TX FIFO at least half full |
| tx_shift_empty | input | 1 | Transmitter fully idle |
| tx_ready | input | 1 | Transmitter can take data |
| err_event | input | 4 | Line error pulses {break, frame, parity, overrun} |
| txf_flush | output | 1 | One-cycle TX FIFO flush strobe |
| rxf_flush | output | 1 | One-cycle RX FIFO flush strobe |
| soft_clear | output | 1 | One-cycle soft-reset strobe |
| cfg_loopback | output | 1 | Loopback mode |
| cfg_break | output | 1 | Drive a break on the line |
| cfg_parity | output | 1 | Parity on |
| cfg_two_stop | output | 1 | Two stop bits |
| cfg_div | output | 10 | Baud divisor |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is an error event that lands in the same cycle as the status read that clears the flags. Only exact cycle alignment between the event pin and the read shows that the set is kept over the clear. The bench drives both in one cycle and then reads the flags again. It also spreads random event pulses, live flag changes and enable writes between status reads. Each time, it checks that irq follows only the paired source, including the TX half source at control bit 8, which is not at the same bit position as its status flag.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned DIV_W  = 10;
  localparam int unsigned N_IRQ  = 9;
  localparam int unsigned N_ERR  = 4;

  // control word bit positions
  localparam int unsigned CB_SOFT   = 31;
  localparam int unsigned CB_TXF    = 15;
  localparam int unsigned CB_RXF    = 14;
  localparam int unsigned CB_MIRROR = 13;
  localparam int unsigned CB_LOOP   = 12;
  localparam int unsigned CB_BREAK  = 11;
  localparam int unsigned CB_PARITY = 10;
  localparam int unsigned CB_STOP2  = 9;

  // status word bit positions
  localparam int unsigned SB_TXF_EMPTY = 13;
  localparam int unsigned SB_RXF_EMPTY = 12;
  localparam int unsigned SB_TXF_FULL  = 11;
  localparam int unsigned SB_TXF_HALF  = 10;
  localparam int unsigned SB_RX_TOGGLE = 9;
  localparam int unsigned SB_RXF_FULL  = 8;
  localparam int unsigned SB_RXF_HALF  = 7;
  localparam int unsigned SB_TX_IDLE   = 6;
  localparam int unsigned SB_TX_READY  = 5;
  localparam int unsigned SB_RX_READY  = 4;

  // control bits that hold state; everything else reads 0
  localparam logic [WORD_W-1:0] CTRL_KEEP = 32'h8000_FFFF;

  typedef enum logic [2:0] {
    SEL_RXBUF  = 3'd0,
    SEL_TXHOLD = 3'd1,
    SEL_CTRL   = 3'd2,
    SEL_STAT   = 3'd3,
    SEL_BAUD   = 3'd4,
    SEL_NONE   = 3'd7
  } csr_sel_e;

  typedef struct packed {
    logic rd_rxbuf;
    logic wr_txhold;
    logic wr_ctrl;
    logic rd_stat;
    logic wr_baud;
  } csr_acc_t;

  // status bit that feeds interrupt enable i
  function automatic int unsigned irq_src_bit(input int unsigned i);
    return (i == 8) ? SB_TXF_HALF : i;
  endfunction

endpackage

// File: rtl/uart_csr_rstsync.sv
module uart_csr_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/uart_csr_decode.sv
module uart_csr_decode
  import uart_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output csr_sel_e          rsel,
  output logic              rd_en,
  output csr_acc_t          acc
);

  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic              aligned;

  assign widx    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    rsel = SEL_NONE;
    if (aligned) begin
      case (widx)
        WIDX_W'(0): rsel = SEL_RXBUF;
        WIDX_W'(1): rsel = SEL_TXHOLD;
        WIDX_W'(2): rsel = SEL_CTRL;
        WIDX_W'(3): rsel = SEL_STAT;
        WIDX_W'(4): rsel = SEL_BAUD;
        default:    rsel = SEL_NONE;
      endcase
    end
  end

  assign rd_en = sel & ~wr;

  always_comb begin
    acc           = '0;
    acc.rd_rxbuf  = rd_en        & (rsel == SEL_RXBUF);
    acc.wr_txhold = (sel & wr)   & (rsel == SEL_TXHOLD);
    acc.wr_ctrl   = (sel & wr)   & (rsel == SEL_CTRL);
    acc.rd_stat   = rd_en        & (rsel == SEL_STAT);
    acc.wr_baud   = (sel & wr)   & (rsel == SEL_BAUD);
  end

endmodule

// File: rtl/uart_csr_ctrl.sv
module uart_csr_ctrl
  import uart_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_baud,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] ctrl_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              wipe,
  output logic              txf_stb_q,
  output logic              rxf_stb_q,
  output logic              soft_stb_q
);

  logic              ctrl_en, div_en;
  logic [WORD_W-1:0] ctrl_d;
  logic [DIV_W-1:0]  div_d;
  logic              txf_stb_d, rxf_stb_d, soft_stb_d;

  // next state
  always_comb begin
    wipe       = wr_ctrl & wdata[CB_SOFT];
    ctrl_en    = wr_ctrl;
    div_en     = wr_baud | wipe;
    ctrl_d     = wipe ? '0 : (wdata & CTRL_KEEP);
    div_d      = wipe ? '0 : wdata[DIV_W-1:0];
    txf_stb_d  = wr_ctrl & wdata[CB_TXF];
    rxf_stb_d  = wr_ctrl & wdata[CB_RXF];
    soft_stb_d = wipe;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      div_q      <= '0;
      txf_stb_q  <= 1'b0;
      rxf_stb_q  <= 1'b0;
      soft_stb_q <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (div_en)  div_q  <= div_d;
      txf_stb_q  <= txf_stb_d;
      rxf_stb_q  <= rxf_stb_d;
      soft_stb_q <= soft_stb_d;
    end
  end

endmodule

// File: rtl/uart_csr_status.sv
module uart_csr_status
  import uart_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stat,
  input  logic              wipe,
  input  logic [N_ERR-1:0]  err_evt,
  input  logic [N_IRQ-1:0]  irq_en,
  input  logic              tx_fifo_empty,
  input  logic              rx_fifo_empty,
  input  logic              tx_fifo_full,
  input  logic              tx_fifo_half,
  input  logic              rx_toggled,
  input  logic              rx_fifo_full,
  input  logic              rx_fifo_half,
  input  logic              tx_shift_empty,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] stat_word,
  output logic              irq_q
);

  logic [N_ERR-1:0] sticky_q, sticky_d;
  logic             sticky_en;
  logic [N_IRQ-1:0] src;
  logic             irq_d;

  // sticky line errors: clear by read or soft reset, a new event wins over the read
  always_comb begin
    sticky_en = rd_stat | wipe | (|err_evt);
    if (wipe) sticky_d = '0;
    else      sticky_d = (rd_stat ? '0 : sticky_q) | err_evt;
  end

  always_comb begin
    stat_word               = '0;
    stat_word[SB_TXF_EMPTY] = tx_fifo_empty;
    stat_word[SB_RXF_EMPTY] = rx_fifo_empty;
    stat_word[SB_TXF_FULL]  = tx_fifo_full;
    stat_word[SB_TXF_HALF]  = tx_fifo_half;
    stat_word[SB_RX_TOGGLE] = rx_toggled;
    stat_word[SB_RXF_FULL]  = rx_fifo_full;
    stat_word[SB_RXF_HALF]  = rx_fifo_half;
    stat_word[SB_TX_IDLE]   = tx_shift_empty;
    stat_word[SB_TX_READY]  = tx_ready;
    stat_word[SB_RX_READY]  = ~rx_fifo_empty;
    stat_word[N_ERR-1:0]    = sticky_q;
  end

  for (genvar g = 0; g < N_IRQ; g++) begin : g_src
    assign src[g] = stat_word[irq_src_bit(g)];
  end

  assign irq_d = |(src & irq_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (sticky_en) sticky_q <= sticky_d;
      irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/uart_csr_unit.sv
module uart_csr_unit
  import uart_csr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [7:0]        rx_byte,
  input  logic [3:0]        rx_flags,
  output logic              rx_pop,
  input  logic              rx_fifo_empty,
  input  logic              rx_fifo_full,
  input  logic              rx_fifo_half,
  input  logic              rx_toggled,
  output logic [7:0]        tx_byte,
  output logic              tx_push,
  input  logic              tx_fifo_empty,
  input  logic              tx_fifo_full,
  input  logic              tx_fifo_half,
  input  logic              tx_shift_empty,
  input  logic              tx_ready,
  input  logic [3:0]        err_event,
  output logic              txf_flush,
  output logic              rxf_flush,
  output logic              soft_clear,
  output logic              cfg_loopback,
  output logic              cfg_break,
  output logic              cfg_parity,
  output logic              cfg_two_stop,
  output logic [9:0]        cfg_div,
  output logic              irq
);

  localparam int unsigned ERR_LSB = CHAR_W + 4;

  logic              rst_sync_n;
  csr_sel_e          rsel;
  logic              rd_en;
  csr_acc_t          acc;
  logic [WORD_W-1:0] ctrl_word;
  logic [DIV_W-1:0]  div_word;
  logic [WORD_W-1:0] stat_word;
  logic [WORD_W-1:0] rxbuf_word;
  logic              wipe;
  logic              push_d, push_q;
  logic [CHAR_W-1:0] txb_q;

  uart_csr_rstsync #(.STAGES(RST_STAGES)) u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  uart_csr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .sel   (bus_sel),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .rsel  (rsel),
    .rd_en (rd_en),
    .acc   (acc)
  );

  uart_csr_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_ctrl    (acc.wr_ctrl),
    .wr_baud    (acc.wr_baud),
    .wdata      (bus_wdata),
    .ctrl_q     (ctrl_word),
    .div_q      (div_word),
    .wipe       (wipe),
    .txf_stb_q  (txf_flush),
    .rxf_stb_q  (rxf_flush),
    .soft_stb_q (soft_clear)
  );

  uart_csr_status u_status (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .rd_stat        (acc.rd_stat),
    .wipe           (wipe),
    .err_evt        (err_event),
    .irq_en         (ctrl_word[N_IRQ-1:0]),
    .tx_fifo_empty  (tx_fifo_empty),
    .rx_fifo_empty  (rx_fifo_empty),
    .tx_fifo_full   (tx_fifo_full),
    .tx_fifo_half   (tx_fifo_half),
    .rx_toggled     (rx_toggled),
    .rx_fifo_full   (rx_fifo_full),
    .rx_fifo_half   (rx_fifo_half),
    .tx_shift_empty (tx_shift_empty),
    .tx_ready       (tx_ready),
    .stat_word      (stat_word),
    .irq_q          (irq)
  );

  // receive buffer view: character plus optional mirrored error tags
  always_comb begin
    rxbuf_word = '0;
    if (!rx_fifo_empty) begin
      rxbuf_word[CHAR_W-1:0] = rx_byte;
      if (ctrl_word[CB_MIRROR]) rxbuf_word[ERR_LSB +: N_ERR] = rx_flags;
    end
  end

  assign rx_pop = acc.rd_rxbuf & ~rx_fifo_empty;

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (rsel)
        SEL_RXBUF: bus_rdata = rxbuf_word;
        SEL_CTRL:  bus_rdata = ctrl_word;
        SEL_STAT:  bus_rdata = stat_word;
        SEL_BAUD:  bus_rdata = {{(WORD_W-DIV_W){1'b0}}, div_word};
        default:   bus_rdata = '0;
      endcase
    end
  end

  // transmit push path
  assign push_d = acc.wr_txhold & ~tx_fifo_full;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      push_q <= 1'b0;
      txb_q  <= '0;
    end else begin
      push_q <= push_d;
      if (acc.wr_txhold) txb_q <= bus_wdata[CHAR_W-1:0];
    end
  end

  assign tx_push      = push_q;
  assign tx_byte      = txb_q;
  assign cfg_loopback = ctrl_word[CB_LOOP];
  assign cfg_break    = ctrl_word[CB_BREAK];
  assign cfg_parity   = ctrl_word[CB_PARITY];
  assign cfg_two_stop = ctrl_word[CB_STOP2];
  assign cfg_div      = div_word;

endmodule

// File: rtl/uart_csr_unit_checks.sv
module uart_csr_unit_checks #(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wd_soft,
  input logic              wd_txf,
  input logic              wd_rxf,
  input logic              tx_fifo_full,
  input logic              rx_fifo_empty,
  input logic [3:0]        err_event,
  input logic              txf_flush,
  input logic              rxf_flush,
  input logic              soft_clear,
  input logic              tx_push,
  input logic              rx_pop,
  input logic [9:0]        cfg_div,
  input logic              irq,
  input logic [8:0]        irq_en,
  input logic [3:0]        sticky
);

  logic wr_ctrl, wr_stat, wr_txh;
  assign wr_ctrl = bus_sel && bus_wr && (bus_addr == ADDR_W'(8));
  assign wr_stat = bus_sel && bus_wr && (bus_addr == ADDR_W'(12));
  assign wr_txh  = bus_sel && bus_wr && (bus_addr == ADDR_W'(4));

  assert_txf_strobe_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    txf_flush |-> $past(wr_ctrl && wd_txf));

  assert_rxf_strobe_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_flush |-> $past(wr_ctrl && wd_rxf));

  assert_soft_clears_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clear |-> (cfg_div == 10'd0));

  assert_event_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_event[0] && !(wr_ctrl && wd_soft)) |=> sticky[0]);

  assert_stat_write_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && (err_event == 4'd0)) |=> (sticky == $past(sticky)));

  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(irq_en) != 9'd0));

  assert_pop_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> !rx_fifo_empty);

  assert_push_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> $past(wr_txh && !tx_fifo_full));

endmodule

bind uart_csr_unit uart_csr_unit_checks #(.ADDR_W(ADDR_W)) u_checks (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .bus_sel       (bus_sel),
  .bus_wr        (bus_wr),
  .bus_addr      (bus_addr),
  .wd_soft       (bus_wdata[31]),
  .wd_txf        (bus_wdata[15]),
  .wd_rxf        (bus_wdata[14]),
  .tx_fifo_full  (tx_fifo_full),
  .rx_fifo_empty (rx_fifo_empty),
  .err_event     (err_event),
  .txf_flush     (txf_flush),
  .rxf_flush     (rxf_flush),
  .soft_clear    (soft_clear),
  .tx_push       (tx_push),
  .rx_pop        (rx_pop),
  .cfg_div       (cfg_div),
  .irq           (irq),
  .irq_en        (ctrl_word[8:0]),
  .sticky        (stat_word[3:0])
);

// File: tb/uart_csr_unit_bench.sv
`timescale 1ns/100ps
module uart_csr_unit_bench;

  localparam logic [4:0] A_RX = 5'h00, A_TX = 5'h04, A_CT = 5'h08, A_ST = 5'h0C, A_DV = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  rx_byte, tx_byte;
  logic [3:0]  rx_flags, err_event;
  logic        rx_pop, rx_fifo_empty, rx_fifo_full, rx_fifo_half, rx_toggled;
  logic        tx_push, tx_fifo_empty, tx_fifo_full, tx_fifo_half, tx_shift_empty, tx_ready;
  logic        txf_flush, rxf_flush, soft_clear;
  logic        cfg_loopback, cfg_break, cfg_parity, cfg_two_stop, irq;
  logic [9:0]  cfg_div;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_ctrl;
  logic [9:0]  m_div;
  logic [3:0]  m_sticky;
  logic        pop_seen;

  always #2.5 clk = ~clk;

  uart_csr_unit u_uart_csr_unit (.*);

  function automatic logic [31:0] exp_stat();
    logic [31:0] s = '0;
    s[13] = tx_fifo_empty; s[12] = rx_fifo_empty; s[11] = tx_fifo_full;
    s[10] = tx_fifo_half;  s[9]  = rx_toggled;    s[8]  = rx_fifo_full;
    s[7]  = rx_fifo_half;  s[6]  = tx_shift_empty; s[5] = tx_ready;
    s[4]  = ~rx_fifo_empty; s[3:0] = m_sticky;
    return s;
  endfunction

  function automatic logic exp_irq();
    logic [31:0] s = exp_stat();
    logic [8:0] src = {s[10], s[7:0]};
    return |(src & m_ctrl[8:0]);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_ev(input logic [4:0] a, input logic [3:0] ev, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; err_event = ev;
    #1;
    d = bus_rdata; pop_seen = rx_pop;
    @(negedge clk);
    bus_sel = 1'b0; err_event = 4'd0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_ev(a, 4'd0, d);
  endtask

  task automatic pulse_ev(input logic [3:0] ev);
    @(negedge clk); err_event = ev;
    @(negedge clk); err_event = 4'd0;
    m_sticky |= ev;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic rand_live();
    @(negedge clk);
    {rx_fifo_empty, rx_fifo_full, rx_fifo_half, rx_toggled} = 4'($urandom);
    {tx_fifo_empty, tx_fifo_full, tx_fifo_half, tx_shift_empty, tx_ready} = 5'($urandom);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h0C5A_17E3));
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    rx_byte = 0; rx_flags = 0; err_event = 0;
    rx_fifo_empty = 1; rx_fifo_full = 0; rx_fifo_half = 0; rx_toggled = 0;
    tx_fifo_empty = 1; tx_fifo_full = 0; tx_fifo_half = 0; tx_shift_empty = 0; tx_ready = 0;
    m_ctrl = 0; m_div = 0; m_sticky = 0;
    repeat (4) @(negedge clk);
    chk("R1 irq in reset", {31'd0, irq}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 strobes", {27'd0, irq, tx_push, txf_flush, rxf_flush, soft_clear}, 0);
    rd(A_CT, d); chk("R1 ctrl", d, 0);
    rd(A_DV, d); chk("R1 div", d, 0);
    rd(A_ST, d); chk("R1 status", d, 32'h0000_3000);

    // R2 control storage and config outputs
    wr(A_CT, 32'h7FFF_3E00); m_ctrl = 32'h0000_3E00;
    rd(A_CT, d); chk("R2 ctrl readback", d, m_ctrl);
    chk("R2 cfg outputs", {28'd0, cfg_loopback, cfg_break, cfg_parity, cfg_two_stop}, 4'hF);
    wr(A_CT, 32'h0000_0A00); m_ctrl = 32'h0000_0A00;
    chk("R2 cfg outputs b", {28'd0, cfg_loopback, cfg_break, cfg_parity, cfg_two_stop}, 4'b0101);

    // R3 flush strobes
    wr(A_CT, 32'h0000_8000); m_ctrl = 32'h0000_8000;
    chk("R3 txf strobe high", {30'd0, txf_flush, rxf_flush}, 2'b10);
    @(negedge clk);
    chk("R3 txf strobe one cycle", {31'd0, txf_flush}, 0);
    wr(A_CT, 32'h0000_4000); m_ctrl = 32'h0000_4000;
    chk("R3 rxf strobe high", {30'd0, txf_flush, rxf_flush}, 2'b01);
    @(negedge clk);
    chk("R3 rxf strobe one cycle", {31'd0, rxf_flush}, 0);
    rd(A_CT, d); chk("R3 readback", d, 32'h0000_4000);

    // R5 divisor field
    wr(A_DV, 32'hFFFF_FFFF); m_div = 10'h3FF;
    rd(A_DV, d); chk("R5 div all ones", d, 32'h0000_03FF);
    wr(A_DV, 32'h0001_2345); m_div = 10'h345;
    rd(A_DV, d); chk("R5 div field", d, 32'h0000_0345);
    chk("R5 cfg_div", {22'd0, cfg_div}, 32'h345);

    // R4 soft reset
    wr(A_CT, 32'h0000_1FFF); m_ctrl = 32'h0000_1FFF;
    pulse_ev(4'b1010);
    wr(A_CT, 32'h8000_0000);
    m_ctrl = 0; m_div = 0; m_sticky = 0;
    chk("R4 soft strobe", {31'd0, soft_clear}, 1);
    @(negedge clk);
    chk("R4 soft one cycle", {31'd0, soft_clear}, 0);
    rd(A_CT, d); chk("R4 ctrl cleared", d, 0);
    rd(A_DV, d); chk("R4 div cleared", d, 0);
    rd(A_ST, d); chk("R4 sticky cleared", d & 32'hF, 0);

    // R6 status layout
    for (int i = 0; i < 8; i++) begin
      rand_live();
      rd(A_ST, d); chk("R6 status layout", d, exp_stat());
    end

    // R7 sticky errors and read-to-clear
    rx_fifo_empty = 1;
    pulse_ev(4'b0101);
    rd(A_ST, d); chk("R7 flags visible", d & 32'hF, 32'h5);
    m_sticky = 0;
    rd(A_ST, d); chk("R7 cleared by read", d & 32'hF, 0);
    pulse_ev(4'b0011);
    rd_ev(A_ST, 4'b1000, d); chk("R7 read with event returns old", d & 32'hF, 32'h3);
    m_sticky = 4'b1000;
    rd(A_ST, d); chk("R7 same-cycle event kept", d & 32'hF, 32'h8);
    m_sticky = 0;

    // R8 status write ignored
    pulse_ev(4'b0110);
    wr(A_CT, 32'h0000_0123); m_ctrl = 32'h0000_0123;
    wr(A_ST, 32'hFFFF_FFFF);
    rd(A_ST, d); chk("R8 status after write", d, exp_stat());
    m_sticky = 0;
    rd(A_CT, d); chk("R8 ctrl untouched", d, m_ctrl);

    // R9 directed interrupt pairing
    @(negedge clk);
    {rx_fifo_empty, rx_fifo_full, rx_fifo_half, rx_toggled} = 4'b1000;
    {tx_fifo_empty, tx_fifo_full, tx_fifo_half, tx_shift_empty, tx_ready} = 5'b10000;
    wr(A_CT, 32'h0000_0100); m_ctrl = 32'h0000_0100;
    @(negedge clk); rx_fifo_full = 1; settle();
    chk("R9 bit8 not fed by rx full", {31'd0, irq}, 0);
    @(negedge clk); tx_fifo_half = 1; settle();
    chk("R9 tx half raises irq", {31'd0, irq}, 1);
    wr(A_CT, 32'h0000_0000); m_ctrl = 0; settle();
    chk("R9 masked irq low", {31'd0, irq}, 0);
    @(negedge clk); tx_fifo_half = 0; rx_fifo_full = 0;

    // R10 receive buffer
    @(negedge clk); rx_fifo_empty = 0; rx_byte = 8'hA5; rx_flags = 4'b1011;
    rd(A_RX, d); chk("R10 mirror off", d, 32'h0000_00A5);
    chk("R10 pop", {31'd0, pop_seen}, 1);
    wr(A_CT, 32'h0000_2000); m_ctrl = 32'h0000_2000;
    rd(A_RX, d); chk("R10 mirror on", d, 32'h0000_B0A5);
    @(negedge clk); rx_fifo_empty = 1;
    rd(A_RX, d); chk("R10 empty read", d, 0);
    chk("R10 no pop when empty", {31'd0, pop_seen}, 0);

    // R11 transmit holding
    wr(A_TX, 32'h0000_01C3);
    chk("R11 push and byte", {23'd0, tx_push, tx_byte}, 32'h1C3);
    @(negedge clk);
    chk("R11 push one cycle", {31'd0, tx_push}, 0);
    @(negedge clk); tx_fifo_full = 1;
    wr(A_TX, 32'h0000_0077);
    chk("R11 no push when full", {31'd0, tx_push}, 0);
    @(negedge clk); tx_fifo_full = 0;

    // R12 unmapped and misaligned
    wr(A_DV, 32'h0000_0155); m_div = 10'h155;
    wr(5'h14, 32'hFFFF_FFFF); wr(5'h18, 32'hFFFF_FFFF); wr(5'h1C, 32'hFFFF_FFFF);
    wr(5'h09, 32'hFFFF_FFFF); wr(5'h11, 32'h0000_0000);
    rd(A_CT, d); chk("R12 ctrl untouched", d, m_ctrl);
    rd(A_DV, d); chk("R12 div untouched", d, 32'h155);
    rd(5'h18, d); chk("R12 unmapped reads 0", d, 0);
    rd(5'h0A, d); chk("R12 misaligned reads 0", d, 0);
    rd(A_TX, d); chk("R12 tx holding reads 0", d, 0);

    // R9 random mix
    for (int i = 0; i < 300; i++) begin
      case ($urandom_range(0, 4))
        0: begin
          d = $urandom & 32'h7FFF_FFFF;
          wr(A_CT, d); m_ctrl = d & 32'h8000_FFFF;
          rd(A_CT, d); chk("R2 random ctrl", d, m_ctrl);
        end
        1: begin
          d = $urandom; wr(A_DV, d); m_div = d[9:0];
          chk("R5 random div", {22'd0, cfg_div}, {22'd0, m_div});
        end
        2: rand_live();
        3: pulse_ev(4'($urandom));
        default: begin
          logic [3:0] ev = 4'($urandom);
          rd_ev(A_ST, ev, d); chk("R7 random status", d, exp_stat());
          m_sticky = ev;
        end
      endcase
      settle();
      chk("R9 random irq", {31'd0, irq}, {31'd0, exp_irq()});
    end

    finish_run();
  end

endmodule